// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block forms the sum of two W-bit unsigned operands (W = 8 by default) with a single 1-bit full adder, working one bit per clock. Each operand sits in its own right-shifting register. Software-side logic writes the operands through two parallel load requests and then raises `start`. A small controller then shifts both registers W times. Each cycle the least significant bits of the two registers pass through the full adder, with the carry held in one flip-flop. Each sum bit enters the accumulator register at its top end. The second operand's register feeds its own shifted-out bit back into its top end, so after W shifts it returns to its original contents.

When the run finishes, `done` pulses for one cycle and the accumulator register holds the truncated sum. `cout` gives the final carry as a status bit. The block trades W cycles of latency for a datapath of one full adder, one flip-flop, two multiplexers and a small counter.

Top module: `serial_adder`

## Requirements
- R1: After reset, `busy`, `done` and `cout` are 0 and both `a_q` and `b_q` read 0.
- R2: While idle, `ld_a` writes `din_a` into register A and `ld_b` writes `din_b` into register B at the next clock edge. The new value is visible on `a_q`/`b_q` after that edge.
- R3: A `start` sampled while idle sets `busy` at the next edge. `busy` then stays high for exactly W cycles, and the counter sits at 0 whenever the block is idle.
- R4: `done` is a one-cycle pulse. It rises on the edge that performs the W-th shift, in the same cycle in which `busy` first reads 0.
- R5: While `done` is high, `a_q` equals (A + B) mod 2^W for the operands present when `start` was accepted.
- R6: While `done` is high, `b_q` equals the B operand present when `start` was accepted.
- R7: While `done` is high, `cout` equals bit W of the (W+1)-bit sum A + B. It holds that value until the next accepted `start`.
- R8: A `start` asserted while busy is ignored: the run length and the result do not change.
- R9: `ld_a` and `ld_b` asserted while busy are ignored: the result and the restored B do not change.
- R10: The carry flip-flop is cleared when `start` is accepted, so a carry left by one addition never enters the next one.
- R11: Bits are processed LSB first. After k shifts (0 ≤ k ≤ W), `a_q` holds sum bits k-1..0 in its top k positions above A shifted right by k, and `b_q` holds B rotated right by k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_a | input | 1 | Load request for register A (honoured only when idle) |
| din_a | input | W | Parallel value for register A |
| ld_b | input | 1 | Load request for register B (honoured only when idle) |
| din_b | input | W | Parallel value for register B |
| start | input | 1 | Begin an addition (honoured only when idle) |
| busy | output | 1 | High during the W shift cycles |
| done | output | 1 | One-cycle pulse when the sum is in register A |
| cout | output | 1 | Carry out of the last addition |
| a_q | output | W | Parallel read-out of register A |
| b_q | output | W | Parallel read-out of register B |

## Verification
If `start` is sampled at edge 0, `busy` reads 1 after that edge and shift k happens at edge k. The sum, the restored B, the carry and the `done` pulse are therefore all due after edge W, and `done` drops after edge W+1. A load shows up one edge after it is requested. The bench drives inputs and samples outputs only on falling clock edges and counts edges from the accepting edge. At every intermediate falling edge it compares the partially shifted registers with values computed arithmetically. The result checks then fall exactly in the cycle the requirements name.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sadd_state_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/serial_adder_shreg.sv
module serial_adder_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sel_par,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         ser_out
);

  logic [W-1:0] nxt;

  // select 1 takes the parallel word, select 0 shifts right with ser_in at the top
  always_comb begin
    if (sel_par) nxt = par_in;
    else         nxt = {ser_in, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end

  assign ser_out = q[0];

  p_shift_right_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel_par) |=> (q[W-2:0] == $past(q[W-1:1])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

endmodule

// File: rtl/serial_adder_ctrl.sv
module serial_adder_ctrl
  import serial_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ld_a,
  input  logic ld_b,
  output logic en_a,
  output logic en_b,
  output logic sel_a,
  output logic sel_b,
  output logic clr_carry,
  output logic run,
  output logic busy,
  output logic done
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  sadd_state_t  state;
  logic [CW-1:0] cnt;
  logic          idle;
  logic          accept;
  logic          clr_cnt;
  logic          term;

  assign idle      = (state == ST_IDLE);
  assign run       = (state == ST_RUN);
  assign accept    = idle && start;
  assign clr_carry = accept;
  assign clr_cnt   = accept;
  assign term      = run && (cnt == LAST);

  // selects are 1 only for an idle load; during the run both registers shift
  assign sel_a = idle && ld_a;
  assign sel_b = idle && ld_b;
  assign en_a  = run || sel_a;
  assign en_b  = run || sel_b;
  assign busy  = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= term;
      if (clr_cnt)   cnt <= '0;
      else if (term) cnt <= '0;
      else if (run)  cnt <= cnt + 1'b1;
      if (accept)    state <= ST_RUN;
      else if (term) state <= ST_IDLE;
    end
  end

  p_cnt_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cnt == '0));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && (cnt != LAST)) |=> (run && (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/serial_adder.sv
module serial_adder
  import serial_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic [W-1:0] din_a,
  input  logic         ld_b,
  input  logic [W-1:0] din_b,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         cout,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);

  logic en_a, en_b, sel_a, sel_b, clr_carry, run;
  logic bit_a, bit_b, sum_bit, carry_q, carry_d;

  serial_adder_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ld_a      (ld_a),
    .ld_b      (ld_b),
    .en_a      (en_a),
    .en_b      (en_b),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .clr_carry (clr_carry),
    .run       (run),
    .busy      (busy),
    .done      (done)
  );

  assign sum_bit = fa_sum(bit_a, bit_b, carry_q);
  assign carry_d = fa_carry(bit_a, bit_b, carry_q);

  // accumulator: sum bit enters at the top
  serial_adder_shreg #(.W(W)) u_reg_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_a),
    .sel_par (sel_a),
    .ser_in  (sum_bit),
    .par_in  (din_a),
    .q       (a_q),
    .ser_out (bit_a)
  );

  // addend: recirculates its own LSB so it is intact after W shifts
  serial_adder_shreg #(.W(W)) u_reg_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_b),
    .sel_par (sel_b),
    .ser_in  (bit_b),
    .par_in  (din_b),
    .q       (b_q),
    .ser_out (bit_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         carry_q <= 1'b0;
    else if (clr_carry) carry_q <= 1'b0;
    else if (run)       carry_q <= carry_d;
  end

  assign cout = carry_q;

  // operand snapshot taken when a run is accepted, used by the checks below
  logic [W-1:0] snap_a, snap_b;
  logic [W:0]   snap_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_a <= '0;
      snap_b <= '0;
    end else if (clr_carry) begin
      snap_a <= a_q;
      snap_b <= b_q;
    end
  end

  assign snap_sum = {1'b0, snap_a} + {1'b0, snap_b};

  p_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (a_q == snap_sum[W-1:0]));

  p_b_restored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (b_q == snap_b));

  p_cout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cout == snap_sum[W]));

  p_carry_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (carry_q == 1'b0));

endmodule

// File: tb/serial_adder_tb.sv
module serial_adder_tb;

  localparam int W      = 8;
  localparam int PERIOD = 10;
  localparam int MASK   = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_a = 1'b0, ld_b = 1'b0, start = 1'b0;
  logic [W-1:0] din_a = '0, din_b = '0;
  logic         busy, done, cout;
  logic [W-1:0] a_q, b_q;

  int total = 0;
  int bad   = 0;

  serial_adder #(.W(W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_a  (ld_a),
    .din_a (din_a),
    .ld_b  (ld_b),
    .din_b (din_b),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cout  (cout),
    .a_q   (a_q),
    .b_q   (b_q)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one addition; disturb=1 pokes start and loads in the middle of the run
  task automatic do_add(input int a, input int b, input bit disturb);
    int sum;
    sum = a + b;
    @(negedge clk);
    ld_a = 1'b1; din_a = W'(a);
    ld_b = 1'b1; din_b = W'(b);
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0;
    chk("R2 load a", int'(a_q), a);
    chk("R2 load b", int'(b_q), b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", int'(busy), 1);
    chk("R10 carry cleared", int'(cout), 0);
    for (int k = 1; k <= W; k++) begin
      int ea, eb;
      if (disturb && k == 3) begin
        start = 1'b1;
        ld_a = 1'b1; din_a = W'(~a);
        ld_b = 1'b1; din_b = W'(~b);
      end
      @(negedge clk);
      if (disturb && k == 3) begin
        start = 1'b0; ld_a = 1'b0; ld_b = 1'b0;
      end
      ea = (((sum & ((1 << k) - 1)) << (W - k)) | (a >> k)) & MASK;
      eb = ((b >> k) | (b << (W - k))) & MASK;
      if (k < W) begin
        chk("R11 partial a", int'(a_q), ea);
        chk("R11 rotated b", int'(b_q), eb);
        chk("R3 busy held", int'(busy), 1);
        chk("R4 no early done", int'(done), 0);
        if (disturb && k == 3) chk("R9 load ignored", int'(b_q), eb);
      end else begin
        chk("R4 done pulse", int'(done), 1);
        chk("R3 busy dropped", int'(busy), 0);
        chk("R5 sum", int'(a_q), sum & MASK);
        chk("R6 b restored", int'(b_q), b);
        chk("R7 carry out", int'(cout), (sum >> W) & 1);
        if (disturb) chk("R8 start ignored result", int'(a_q), sum & MASK);
      end
    end
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
    chk("R8 no restart", int'(busy), 0);
    chk("R7 carry held", int'(cout), (sum >> W) & 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cout", int'(cout), 0);
    chk("R1 a_q", int'(a_q), 0);
    chk("R1 b_q", int'(b_q), 0);

    // corners: full carry chain, then a zero add to show carry does not leak (R10)
    do_add(255, 1, 1'b0);
    do_add(0, 0, 1'b0);
    do_add(255, 255, 1'b1);
    do_add(128, 128, 1'b0);
    do_add(170, 85, 1'b1);

    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 13) begin
        do_add(a, b, ((a + b) % 3) == 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule